// File: doc/BRIEF.md
# SPI Master with Pattern-Driven Chip Selects

This block is a single-bus SPI master that sends and receives one 8-bit frame at a time in mode 0. It has eight chip-select outputs. A fixed active-low select cannot serve every slave, so each select output shows a programmable bit pattern instead. One pattern applies while the bus is idle. A second pattern is supplied with every transmit word and applies for the duration of that frame. Slaves with active-high and active-low selects can therefore share the same bus.

Software talks to the block through a simple write port with four word addresses:

| Address | Contents |
|---|---|
| 0 | Idle pattern, bits 7:0 |
| 1 | Pin-enable mask, bits 7:0 |
| 2 | Transmit word: data byte in bits 7:0, frame select pattern in bits 15:8 |
| 3 | Clock divider value D, bits 7:0 |

The half-period of SCLK is H = D+1 system cycles. A select pin whose mask bit is clear is non-functional and is held at 0.

The engine runs through four states:

| State | Role |
|---|---|
| IDLE | Waits for a transmit write. |
| LEAD | Select setup, lasts H cycles. |
| SHIFT | 15 half-periods of SCLK, starting with SCLK high. |
| TRAIL | Select hold, lasts H cycles. |

The transitions are:

| Transition | Condition |
|---|---|
| IDLE to LEAD | A transmit write arrives while idle. |
| LEAD to SHIFT | The half-period counter expires. Rising edge 1. |
| SHIFT to SHIFT | Each expiry inside the frame toggles SCLK. |
| SHIFT to TRAIL | Expiry of the last high half. Final falling edge. |
| TRAIL to IDLE | The counter expires. Done is pulsed. |

Top module: `spi_pcs_master`

## Requirements
- R1: After reset the outputs are as follows. cs_o is 0xFF, because the idle pattern and the mask both reset to 0xFF. busy, done, sclk and mosi are 0.
- R2: While busy is low, cs_o equals idle pattern AND pin-enable mask. A select pin with mask bit 0 therefore reads 0 at all times.
- R3: While busy is high, cs_o equals the frame pattern (bits 15:8 of the transmit word) AND the mask.
- R4: busy, and the frame pattern on cs_o, start in the cycle after the transmit write. The first rising SCLK edge comes H cycles later.
- R5: SCLK idles low. A frame has exactly 8 rising edges, with high and low phases of H cycles each.
- R6: MOSI sends bits 7:0 of the transmit word MSB first. It changes only while SCLK is low, so it is stable at each rising edge.
- R7: MISO is sampled at each rising SCLK edge. The byte is assembled MSB first and shown on rx_data when done is high.
- R8: busy stays high for exactly 17*H cycles, then falls while cs_o returns to the idle pattern.
- R9: done is a single-cycle pulse, in the first cycle in which busy is low again.
- R10: A transmit write while busy is ignored. The frame pattern, the MOSI data and the frame length are unchanged, and no new frame starts afterwards.
- R11: An idle-pattern write while busy does not change cs_o during the current frame. It appears on cs_o from the first idle cycle.
- R12: With idle pattern 0xFE and frame pattern 0x01, select 0 rests low and is high only during the frame. Selects 7:1 behave the opposite way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register word address |
| wr_data | input | 16 | Register write data |
| miso | input | 1 | Serial data from slave |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data to slave |
| cs_o | output | 8 | Chip-select outputs |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle completion pulse |
| rx_data | output | 8 | Received byte |

## Verification
Every result is timed from the clock edge that accepts the transmit write, counted in cycles of H:

- The frame pattern on cs_o and busy are due one cycle after that edge.
- The first SCLK high is due H cycles later.
- busy falls 17*H cycles after it rose, in the same cycle as done, rx_data and the return of cs_o to the idle pattern.

The bench samples on the falling clock edge. It counts busy cycles from the first post-write sample, so each of these instants is compared at an exact cycle count. MOSI and the MISO stimulus are handled at SCLK edges, which lie away from the system-clock sampling points.

// File: rtl/spi_pcs_pkg.sv
package spi_pcs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LEAD,
        ST_SHIFT,
        ST_TRAIL
    } spi_state_e;

    localparam logic [1:0] ADDR_IDLE_PAT = 2'd0;
    localparam logic [1:0] ADDR_PIN_EN   = 2'd1;
    localparam logic [1:0] ADDR_TX_WORD  = 2'd2;
    localparam logic [1:0] ADDR_DIVIDER  = 2'd3;

endpackage

// File: rtl/spi_pcs_regs.sv
module spi_pcs_regs
    import spi_pcs_pkg::*;
#(
    parameter int NUM_CS = 8,
    parameter int DATA_W = 8,
    parameter int DIV_W  = 8,
    localparam int WR_W  = DATA_W + NUM_CS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [WR_W-1:0]   wr_data,
    input  logic              busy,
    output logic              start,
    output logic [DATA_W-1:0] tx_data,
    output logic [DIV_W-1:0]  div_val,
    output logic [NUM_CS-1:0] idle_pat,
    output logic [NUM_CS-1:0] pin_en,
    output logic [NUM_CS-1:0] frame_pat
);

    logic [NUM_CS-1:0] idle_pat_q;
    logic [NUM_CS-1:0] pin_en_q;
    logic [NUM_CS-1:0] frame_pat_q;
    logic [DIV_W-1:0]  div_q;

    always_comb begin
        start   = wr_en && (wr_addr == ADDR_TX_WORD) && !busy;
        tx_data = wr_data[DATA_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idle_pat_q  <= '1;
            pin_en_q    <= '1;
            frame_pat_q <= '1;
            div_q       <= '0;
        end else begin
            if (wr_en && wr_addr == ADDR_IDLE_PAT) idle_pat_q <= wr_data[NUM_CS-1:0];
            if (wr_en && wr_addr == ADDR_PIN_EN)   pin_en_q   <= wr_data[NUM_CS-1:0];
            if (wr_en && wr_addr == ADDR_DIVIDER)  div_q      <= wr_data[DIV_W-1:0];
            if (start) frame_pat_q <= wr_data[WR_W-1:DATA_W];
        end
    end

    assign idle_pat  = idle_pat_q;
    assign pin_en    = pin_en_q;
    assign frame_pat = frame_pat_q;
    assign div_val   = div_q;

    // R10: a transmit write during a frame leaves the latched frame pattern alone
    a_r10_pattern_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_en && wr_addr == ADDR_TX_WORD) |=> $stable(frame_pat_q));

endmodule

// File: rtl/spi_pcs_engine.sv
module spi_pcs_engine
    import spi_pcs_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 8,
    localparam int HW        = $clog2(2 * DATA_W),
    localparam int LAST_HALF = 2 * DATA_W - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] tx_data,
    input  logic [DIV_W-1:0]  div_val,
    input  logic              miso,
    output logic              busy,
    output logic              sclk,
    output logic              mosi,
    output logic              done,
    output logic [DATA_W-1:0] rx_data
);

    spi_state_e        state_q, state_d;
    logic [DIV_W-1:0]  cnt_q;
    logic [DIV_W-1:0]  div_q;
    logic [HW-1:0]     half_q;
    logic [DATA_W-1:0] tx_sr, rx_sr, rx_q;
    logic              done_q;
    logic              tick;

    assign tick = (cnt_q == div_q);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_LEAD;
            ST_LEAD:  if (tick) state_d = ST_SHIFT;
            ST_SHIFT: if (tick && half_q == HW'(LAST_HALF)) state_d = ST_TRAIL;
            ST_TRAIL: if (tick) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath: half-period counter, shift registers, completion
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            div_q  <= '0;
            half_q <= '0;
            tx_sr  <= '0;
            rx_sr  <= '0;
            rx_q   <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (state_q == ST_IDLE || tick) cnt_q <= '0;
            else                            cnt_q <= cnt_q + 1'b1;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        div_q <= div_val;
                        tx_sr <= tx_data;
                    end
                end
                ST_LEAD: begin
                    if (tick) begin
                        half_q <= '0;
                        rx_sr  <= {rx_sr[DATA_W-2:0], miso};
                    end
                end
                ST_SHIFT: begin
                    if (tick) begin
                        half_q <= half_q + 1'b1;
                        if (!half_q[0]) tx_sr <= {tx_sr[DATA_W-2:0], 1'b0};
                        else            rx_sr <= {rx_sr[DATA_W-2:0], miso};
                    end
                end
                ST_TRAIL: begin
                    if (tick) begin
                        done_q <= 1'b1;
                        rx_q   <= rx_sr;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy    = (state_q != ST_IDLE);
        sclk    = (state_q == ST_SHIFT) && !half_q[0];
        mosi    = busy ? tx_sr[DATA_W-1] : 1'b0;
        done    = done_q;
        rx_data = rx_q;
    end

    a_r5_sclk_low_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sclk);
    a_r6_mosi_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(mosi));
    a_r4_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));
    a_r9_done_at_fall: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: rtl/spi_pcs_select.sv
module spi_pcs_select #(
    parameter int NUM_CS = 8
) (
    input  logic              active,
    input  logic [NUM_CS-1:0] idle_pat,
    input  logic [NUM_CS-1:0] frame_pat,
    input  logic [NUM_CS-1:0] pin_en,
    output logic [NUM_CS-1:0] cs_o
);

    for (genvar i = 0; i < NUM_CS; i++) begin : g_pin
        assign cs_o[i] = pin_en[i] & (active ? frame_pat[i] : idle_pat[i]);
    end

endmodule

// File: rtl/spi_pcs_master.sv
module spi_pcs_master
    import spi_pcs_pkg::*;
#(
    parameter int NUM_CS = 8,
    parameter int DATA_W = 8,
    parameter int DIV_W  = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [1:0]               wr_addr,
    input  logic [DATA_W+NUM_CS-1:0] wr_data,
    input  logic                     miso,
    output logic                     sclk,
    output logic                     mosi,
    output logic [NUM_CS-1:0]        cs_o,
    output logic                     busy,
    output logic                     done,
    output logic [DATA_W-1:0]        rx_data
);

    logic              start;
    logic [DATA_W-1:0] tx_data;
    logic [DIV_W-1:0]  div_val;
    logic [NUM_CS-1:0] idle_pat, pin_en, frame_pat;

    spi_pcs_regs #(.NUM_CS(NUM_CS), .DATA_W(DATA_W), .DIV_W(DIV_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .busy      (busy),
        .start     (start),
        .tx_data   (tx_data),
        .div_val   (div_val),
        .idle_pat  (idle_pat),
        .pin_en    (pin_en),
        .frame_pat (frame_pat)
    );

    spi_pcs_engine #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_engine (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .tx_data (tx_data),
        .div_val (div_val),
        .miso    (miso),
        .busy    (busy),
        .sclk    (sclk),
        .mosi    (mosi),
        .done    (done),
        .rx_data (rx_data)
    );

    spi_pcs_select #(.NUM_CS(NUM_CS)) u_select (
        .active    (busy),
        .idle_pat  (idle_pat),
        .frame_pat (frame_pat),
        .pin_en    (pin_en),
        .cs_o      (cs_o)
    );

    a_r2_idle_pattern: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (cs_o == (idle_pat & pin_en)));
    a_r3_frame_pattern: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cs_o == (frame_pat & pin_en)));

endmodule

// File: tb/test_spi_pcs_master.sv
module test_spi_pcs_master;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [7:0] div;
        logic [7:0] idle;
        logic [7:0] en;
        logic [7:0] pat;
        logic [7:0] txd;
        logic [7:0] slv;
    } xfer_vec_t;

    localparam int NVEC = 5;
    localparam xfer_vec_t VEC [NVEC] = '{
        '{8'd0, 8'hFF, 8'hFF, 8'hFE, 8'hA5, 8'h3C},
        '{8'd2, 8'hFE, 8'hFF, 8'h01, 8'h5A, 8'hC3},
        '{8'd1, 8'hFF, 8'h0F, 8'hF7, 8'h81, 8'h7E},
        '{8'd3, 8'h00, 8'hFF, 8'h80, 8'hFF, 8'h00},
        '{8'd0, 8'hAA, 8'hF0, 8'h55, 8'h00, 8'hFF}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        miso;
    logic        sclk, mosi, busy, done;
    logic [7:0]  cs_o, rx_data;

    int   n_cmp = 0;
    int   n_bad = 0;
    bit   finished = 1'b0;
    int   rises = 0;
    int   rise_base = 0;
    logic [7:0] slv_byte = '0;
    logic [7:0] mosi_cap = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_pcs_master i_spi_pcs_master (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .miso    (miso),
        .sclk    (sclk),
        .mosi    (mosi),
        .cs_o    (cs_o),
        .busy    (busy),
        .done    (done),
        .rx_data (rx_data)
    );

    // slave model: presents the next bit after each rising edge, captures MOSI
    always @(posedge sclk) begin
        mosi_cap <= {mosi_cap[6:0], mosi};
        rises    <= rises + 1;
    end

    always_comb begin
        if (rises - rise_base < 8) miso = slv_byte[7 - (rises - rise_base)];
        else                       miso = 1'b0;
    end

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    // runs one frame and checks timing, selects and data; returns at first idle sample
    task automatic run_frame(input xfer_vec_t v);
        int h;
        int cyc;
        int first_hi;
        int r0;
        h = int'(v.div) + 1;
        write_reg(2'd3, {8'h00, v.div});
        write_reg(2'd0, {8'h00, v.idle});
        write_reg(2'd1, {8'h00, v.en});
        check("R2 idle pattern", cs_o, v.idle & v.en);
        slv_byte  = v.slv;
        rise_base = rises;
        r0        = rises;
        write_reg(2'd2, {v.pat, v.txd});
        cyc = 0;
        first_hi = -1;
        check("R4 busy after write", busy, 1);
        check("R3 frame pattern", cs_o, v.pat & v.en);
        if (v.idle == 8'hFE && v.pat == 8'h01)
            check("R12 active-high select 0", cs_o[0], 1);
        while (busy && cyc < 10000) begin
            if (sclk && first_hi < 0) first_hi = cyc;
            cyc++;
            @(negedge clk);
        end
        check("R4 first SCLK rise", first_hi, h);
        check("R8 busy length", cyc, 17 * h);
        check("R5 rising edges", rises - r0, 8);
        check("R6 MOSI byte", mosi_cap, v.txd);
        check("R9 done at busy fall", done, 1);
        check("R7 received byte", rx_data, v.slv);
        check("R8 selects back to idle", cs_o, v.idle & v.en);
        if (v.idle == 8'hFE) check("R12 select 0 rests low", cs_o[0], 0);
        @(negedge clk);
        check("R9 done one cycle", done, 0);
        check("R5 SCLK idle low", sclk, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 cs reset", cs_o, 8'hFF);
        check("R1 busy reset", busy, 0);
        check("R1 done reset", done, 0);
        check("R1 sclk reset", sclk, 0);
        check("R1 mosi reset", mosi, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 cs after release", cs_o, 8'hFF);

        for (int i = 0; i < NVEC; i++) run_frame(VEC[i]);

        // R10 / R11: writes during a frame
        begin
            int cyc;
            write_reg(2'd3, 16'h0000);
            write_reg(2'd0, 16'h00FF);
            write_reg(2'd1, 16'h00FF);
            slv_byte  = 8'h96;
            rise_base = rises;
            write_reg(2'd2, {8'hFE, 8'h3C});
            // we are one sample into the frame; issue competing writes
            write_reg(2'd2, {8'h01, 8'hC3});
            check("R10 pattern kept", cs_o, 8'hFE);
            write_reg(2'd0, 16'h000F);
            check("R11 no effect during frame", cs_o, 8'hFE);
            cyc = 4;
            while (busy && cyc < 10000) begin
                cyc++;
                @(negedge clk);
            end
            check("R10 frame length kept", cyc, 17);
            check("R10 MOSI data kept", mosi_cap, 8'h3C);
            check("R7 received byte", rx_data, 8'h96);
            check("R11 new idle pattern", cs_o, 8'h0F);
            repeat (40) begin
                @(negedge clk);
                if (busy) break;
            end
            check("R10 no late frame", busy, 0);
        end

        // R2 masked pins held at 0
        write_reg(2'd0, 16'h00FF);
        write_reg(2'd1, 16'h0033);
        check("R2 mask forces 0", cs_o, 8'h33);

        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            finished = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule